// File: doc/BRIEF.md
# Sector Load Buffer with Load-Window Timer

This block gathers byte writes for one 128-byte sector into a local page buffer and then reprograms that sector of an internal backing array as one unit. An unlock decoder elsewhere in the chip pulses `prog_en` to arm the block. The first byte written after arming fixes the target sector and opens a load window. Later bytes for that sector may arrive in any order, and a byte written twice keeps its newer value. The window closes when no accepted write has arrived for `WIN_CYC` clock cycles.

Once the window closes, the block reports busy for a program period of `PROG_CYC` cycles. On the last cycle of that period it writes the whole sector row in a single step. The sector is erased first, in effect, so every byte not loaded in the window reads FFh afterwards. The block also shows the address and data of the most recent accepted byte. A write aimed at a different sector while the window is open is dropped and raises a one-cycle error pulse. A synchronous read port with one cycle of latency gives access to the array. Timing is counted in cycles, and the array size is set by the number of sector-address bits (nine bits gives the full 64K x 8 map).

Top module: `sector_load_buffer`

## Requirements
- R1: After reset `busy`, `sect_err`, `last_addr` and `last_data` are all 0, and every array location reads FFh.
- R2: Byte writes are accepted only after a `prog_en` pulse arrives while the block is idle. A write made without arming opens no window, never raises `busy`, and leaves `last_addr` and `last_data` unchanged.
- R3: Address bits [AW-1:7] select the sector and bits [6:0] select the byte within it. Bytes may be loaded in any order. A repeated byte keeps the value of its latest write. `last_addr` and `last_data` show an accepted write in the cycle after it is sampled.
- R4: `busy` rises exactly `WIN_CYC` clock edges after the edge that sampled the last accepted write. A write sampled exactly `WIN_CYC` edges after the previous one keeps the window open.
- R5: `busy` stays high for exactly `PROG_CYC` cycles.
- R6: The sector row is written only when `busy` falls. While `busy` is high, reads return the old contents. Afterwards each loaded byte holds its value, each unloaded byte of the sector reads FFh, and other sectors are unchanged.
- R7: While the window is open, a write whose sector bits differ from the latched sector is dropped. It changes neither array nor `last_addr`/`last_data`, and it gives a one-cycle `sect_err` pulse in the following cycle.
- R8: Writes that arrive while `busy` is high are ignored.
- R9: Each new window starts with an empty buffer, so bytes loaded into the same sector by an earlier window read FFh unless they are loaded again.
- R10: `rd_data` shows the array byte at the `rd_addr` sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Arming pulse from the unlock decoder |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | AW | Byte write address (sector bits above byte bits) |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array read data, one cycle after the address |
| busy | output | 1 | High during the program period |
| sect_err | output | 1 | One-cycle pulse for a dropped off-sector write |
| last_addr | output | AW | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |

## Verification
The main load path is driven from a vector table. It loads bytes out of order, includes a repeated byte offset, uses both ends of the byte range, and spaces writes with gaps from zero up to the longest gap that still keeps the window open. This separates a correct idle timer from one that closes too early or counts writes, and separates last-write-wins from first-write-wins. Directed cases then cover the rest: a write before arming, a write during busy, and an off-sector write. They also check a second window on the same sector, which tells a cleared valid mask apart from one that is left stale, and they check the old-versus-new contents seen during and after the program period.

// File: rtl/slb_pkg.sv
// Package: shared constants and state encoding for the sector load buffer.
// Assumes a fixed 128-byte sector (7 byte-offset bits).
package slb_pkg;
    localparam int PAGE_BYTES = 128;
    localparam int OFS_W      = 7;
    localparam int ROW_W      = PAGE_BYTES * 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOAD  = 2'd2,
        ST_PROG  = 2'd3
    } slb_state_e;
endpackage

// File: rtl/slb_window_ctrl.sv
// Module: slb_window_ctrl
// Sequencer for arming, the load window, the idle-gap timer and the program
// period. It decides which writes are accepted and when the row is committed.
// Assumes WIN_CYC >= 2 and PROG_CYC >= 2.
module slb_window_ctrl
    import slb_pkg::*;
#(
    parameter int SECT_W   = 4,
    parameter int WIN_CYC  = 64,
    parameter int PROG_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              wr_en,
    input  logic [SECT_W-1:0] wr_sect,
    output logic              accept,
    output logic              first_wr,
    output logic              commit,
    output logic              busy,
    output logic              sect_err,
    output logic [SECT_W-1:0] sect_q
);
    localparam int IW = $clog2(WIN_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);

    slb_state_e    st;
    logic [IW-1:0] idle_cnt;
    logic [PW-1:0] prog_cnt;
    logic          mism;
    logic          win_done;

    // Classify the current write and the end-of-period conditions.
    always_comb begin
        first_wr = wr_en && (st == ST_ARMED);
        accept   = first_wr || (wr_en && (st == ST_LOAD) && (wr_sect == sect_q));
        mism     = wr_en && (st == ST_LOAD) && (wr_sect != sect_q);
        win_done = (st == ST_LOAD) && !accept && (idle_cnt == IW'(WIN_CYC - 1));
        commit   = (st == ST_PROG) && (prog_cnt == PW'(PROG_CYC - 1));
        busy     = (st == ST_PROG);
    end

    // State sequence: idle -> armed -> loading -> programming -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  if (prog_en)  st <= ST_ARMED;
                ST_ARMED: if (first_wr) st <= ST_LOAD;
                ST_LOAD:  if (win_done) st <= ST_PROG;
                ST_PROG:  if (commit)   st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Latch the target sector from the first byte of the window.
    always_ff @(posedge clk) begin
        if (!rst_n)        sect_q <= '0;
        else if (first_wr) sect_q <= wr_sect;
    end

    // Count idle cycles since the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)              idle_cnt <= '0;
        else if (accept)         idle_cnt <= '0;
        else if (st == ST_LOAD)  idle_cnt <= idle_cnt + 1'b1;
    end

    // Count cycles of the program period.
    always_ff @(posedge clk) begin
        if (!rst_n)              prog_cnt <= '0;
        else if (win_done)       prog_cnt <= '0;
        else if (st == ST_PROG)  prog_cnt <= prog_cnt + 1'b1;
    end

    // Register the off-sector error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sect_err <= 1'b0;
        else        sect_err <= mism;
    end

    // R4
    idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |-> (idle_cnt < IW'(WIN_CYC)));

    // R5
    prog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |-> (prog_cnt < PW'(PROG_CYC)));

    // R7
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sect_err |-> $past(wr_en && (st == ST_LOAD)));
endmodule

// File: rtl/slb_page_buf.sv
// Module: slb_page_buf
// One sector of byte storage plus a per-byte valid mask. It produces the
// erased-then-programmed row image, with FFh wherever no byte was loaded.
// Assumes clear is asserted only together with wr (first byte of a window).
module slb_page_buf
    import slb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             clear,
    input  logic [OFS_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [ROW_W-1:0] row_img
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    // Track which bytes were loaded; a new window starts from just this byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr) begin
            if (clear)  valid_q <= PAGE_BYTES'(1) << idx;
            else        valid_q[idx] <= 1'b1;
        end
    end

    // Store byte data; the latest write to an offset wins.
    always_ff @(posedge clk) begin
        if (wr) data_q[idx] <= din;
    end

    // Build the row image: loaded bytes, else the erased value.
    generate
        for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_img
            assign row_img[i*8 +: 8] = valid_q[i] ? data_q[i] : 8'hFF;
        end
    endgenerate

    // R9
    clear_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && clear) |=> ($countones(valid_q) == 1));
endmodule

// File: rtl/slb_sector_array.sv
// Module: slb_sector_array
// Backing store organised as one full-sector row per entry, so a sector is
// rewritten in a single cycle. Byte read port with one cycle of latency.
// Assumes the reset value of every byte is the erased value FFh.
module slb_sector_array
    import slb_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [SECT_W-1:0]       w_sect,
    input  logic [ROW_W-1:0]        w_row,
    input  logic [SECT_W+OFS_W-1:0] r_addr,
    output logic [7:0]              r_data
);
    localparam int NSECT = 1 << SECT_W;

    logic [ROW_W-1:0] mem [NSECT];

    // Erase on reset; otherwise commit a whole row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSECT; s++) mem[s] <= '1;
        end else if (we) begin
            mem[w_sect] <= w_row;
        end
    end

    // Registered byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) r_data <= 8'hFF;
        else        r_data <= mem[r_addr[SECT_W+OFS_W-1:OFS_W]][{r_addr[OFS_W-1:0], 3'b000} +: 8];
    end
endmodule

// File: rtl/sector_load_buffer.sv
// Module: sector_load_buffer (top)
// Collects byte writes for one sector after arming and closes the load window
// on an idle gap. After a fixed program period it rewrites the sector, with
// unloaded bytes erased. Assumes prog_en comes from a separate unlock decoder.
module sector_load_buffer
    import slb_pkg::*;
#(
    parameter int SECT_W   = 4,
    parameter int WIN_CYC  = 64,
    parameter int PROG_CYC = 256,
    localparam int AW      = SECT_W + OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          sect_err,
    output logic [AW-1:0] last_addr,
    output logic [7:0]    last_data
);
    logic              accept;
    logic              first_wr;
    logic              commit;
    logic [SECT_W-1:0] sect_q;
    logic [ROW_W-1:0]  row_img;

    slb_window_ctrl #(
        .SECT_W   (SECT_W),
        .WIN_CYC  (WIN_CYC),
        .PROG_CYC (PROG_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .wr_en    (wr_en),
        .wr_sect  (wr_addr[AW-1:OFS_W]),
        .accept   (accept),
        .first_wr (first_wr),
        .commit   (commit),
        .busy     (busy),
        .sect_err (sect_err),
        .sect_q   (sect_q)
    );

    slb_page_buf u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (accept),
        .clear   (first_wr),
        .idx     (wr_addr[OFS_W-1:0]),
        .din     (wr_data),
        .row_img (row_img)
    );

    slb_sector_array #(
        .SECT_W (SECT_W)
    ) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (commit),
        .w_sect (sect_q),
        .w_row  (row_img),
        .r_addr (rd_addr),
        .r_data (rd_data)
    );

    // Record the address and data of the last accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (accept) begin
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(last_addr) && $stable(last_data)));

    // R6
    commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

    // R7
    err_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sect_err) |-> $stable(last_addr));
endmodule

// File: tb/sector_load_buffer_bench.sv
// Bench for sector_load_buffer: a vector table loaded in one window, then
// directed tests for reset, ignored writes, window timing and erase.
module sector_load_buffer_bench;
    localparam int SECT_W = 4;
    localparam int WIN    = 8;
    localparam int PROG   = 20;
    localparam int AW     = SECT_W + 7;
    localparam int NBYTES = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [3:0]    gap;
    } vec_t;

    // Sector 3 (base 0x180), out of order, repeated offset 5, gaps up to WIN-1.
    localparam vec_t VECS [8] = '{
        '{addr: 11'h1CD, data: 8'h3C, gap: 4'd0},
        '{addr: 11'h185, data: 8'hA1, gap: 4'd7},
        '{addr: 11'h1FF, data: 8'h00, gap: 4'd2},
        '{addr: 11'h180, data: 8'h5A, gap: 4'd0},
        '{addr: 11'h1C0, data: 8'hC3, gap: 4'd3},
        '{addr: 11'h185, data: 8'h17, gap: 4'd7},
        '{addr: 11'h1A1, data: 8'h6E, gap: 4'd1},
        '{addr: 11'h1E4, data: 8'h81, gap: 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          prog_en;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          busy;
    logic          sect_err;
    logic [AW-1:0] last_addr;
    logic [7:0]    last_data;

    int   errors = 0;
    int   checks = 0;
    int   cyc    = 0;
    logic done   = 1'b0;

    logic [7:0] model [NBYTES];
    logic [7:0] pbuf  [128];
    logic       pval  [128];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sector_load_buffer #(.SECT_W(SECT_W), .WIN_CYC(WIN), .PROG_CYC(PROG)) u_sector_load_buffer (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .sect_err(sect_err), .last_addr(last_addr), .last_data(last_data)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_arm();
        prog_en = 1'b1;
        @(negedge clk);
        prog_en = 1'b0;
        for (int i = 0; i < 128; i++) pval[i] = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic commit_model(input int sect);
        for (int i = 0; i < 128; i++) model[sect*128 + i] = pval[i] ? pbuf[i] : 8'hFF;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy !== 1'b0 && g < 1000) begin @(negedge clk); g++; end
    endtask

    task automatic check_sector(input int sect, input string req);
        logic [7:0] d;
        int bad = 0;
        int ba = 0; int bact = 0; int bexp = 0;
        for (int i = 0; i < 128; i++) begin
            do_read(AW'(sect*128 + i), d);
            if (d !== model[sect*128 + i]) begin
                if (bad == 0) begin ba = sect*128 + i; bact = d; bexp = model[sect*128 + i]; end
                bad++;
            end
        end
        chk(bad == 0, req, bact, bexp);
        if (bad != 0) $display("  first mismatch at address %0h, %0d bytes differ", ba, bad);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R0 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic       rose_early;
        int         t_rise;
        rst_n = 1'b0; prog_en = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(sect_err === 1'b0, "R1 sect_err", sect_err, 0);
        chk(last_addr === '0 && last_data === '0, "R1 last", {last_addr, last_data}, 0);
        do_read(11'h1CD, d);
        chk(d === 8'hFF, "R1 erased read", d, 8'hFF);

        // R2 write without arming is ignored
        do_write(11'h185, 8'h11);
        rose_early = 1'b0;
        repeat (WIN + 3) begin @(negedge clk); if (busy) rose_early = 1'b1; end
        chk(!rose_early, "R2 no busy without arm", rose_early, 0);
        chk(last_addr === '0, "R2 last_addr unchanged", last_addr, 0);

        // R3 R4 vector table: out-of-order loads with gaps
        do_arm();
        rose_early = 1'b0;
        foreach (VECS[k]) begin
            do_write(VECS[k].addr, VECS[k].data);
            pbuf[VECS[k].addr[6:0]] = VECS[k].data;
            pval[VECS[k].addr[6:0]] = 1'b1;
            chk(last_addr === VECS[k].addr && last_data === VECS[k].data,
                "R3 last byte", {last_addr, last_data}, {VECS[k].addr, VECS[k].data});
            if (k != 7) repeat (int'(VECS[k].gap)) begin @(negedge clk); if (busy) rose_early = 1'b1; end
        end
        chk(!rose_early, "R4 window held by gaps up to limit", rose_early, 0);
        repeat (WIN - 1) @(negedge clk);
        chk(busy === 1'b0, "R4 busy low one cycle before limit", busy, 0);
        @(negedge clk);
        chk(busy === 1'b1, "R4 busy at limit", busy, 1);
        t_rise = cyc;

        // R8 write during busy ignored; R6 old contents while busy
        do_write(11'h1CD, 8'h99);
        chk(last_addr === 11'h1E4 && last_data === 8'h81, "R8 write during busy",
            {last_addr, last_data}, {11'h1E4, 8'h81});
        do_read(11'h1CD, d);
        chk(d === 8'hFF, "R6 old data while busy", d, 8'hFF);
        wait_idle();
        chk(cyc - t_rise == PROG, "R5 busy length", cyc - t_rise, PROG);
        commit_model(3);
        check_sector(3, "R6 R3 sector 3 contents");
        do_read(11'h100, d);
        chk(d === 8'hFF, "R6 other sector untouched", d, 8'hFF);

        // R7 off-sector write dropped with error pulse; R9 mask cleared
        do_arm();
        do_write(11'h190, 8'h44);
        pbuf[16] = 8'h44; pval[16] = 1'b1;
        do_write(11'h290, 8'h55);
        chk(sect_err === 1'b1, "R7 error pulse", sect_err, 1);
        chk(last_addr === 11'h190, "R7 last_addr kept", last_addr, 11'h190);
        @(negedge clk);
        chk(sect_err === 1'b0, "R7 pulse one cycle", sect_err, 0);
        repeat (WIN + 2) @(negedge clk);
        wait_idle();
        commit_model(3);
        check_sector(3, "R9 earlier bytes erased");
        do_read(11'h290, d);
        chk(d === 8'hFF, "R7 off-sector byte not written", d, 8'hFF);

        // R2 idle write after commit without re-arming
        do_write(11'h190, 8'h77);
        repeat (WIN + 2) @(negedge clk);
        chk(busy === 1'b0, "R2 idle write no busy", busy, 0);
        do_read(11'h190, d);
        chk(d === 8'h44, "R2 idle write ignored", d, 8'h44);

        // R10 one-cycle read latency
        rd_addr = 11'h180;
        chk(rd_data === 8'h44, "R10 data held until edge", rd_data, 8'h44);
        @(negedge clk);
        chk(rd_data === 8'hFF, "R10 data after edge", rd_data, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule